// File: doc/BRIEF.md
# Lane Metaframe Checker and Skip Remover

This block sits on one receive lane after word alignment and descrambling. Each input word is 64 data bits plus a control flag. The block finds the metaframe boundaries by looking for sync words at a fixed spacing and holds frame lock. It drops skip words and every other framing word without notice. It also recomputes a CRC-32 over each metaframe and checks it against the value the transmitter placed in the diagnostic word that closes the metaframe. Data words and non-framing control words are passed on, one cycle later, only while the lane is locked.

The diagnostic word also carries two status bits, one for the far-end lane and one for the link. They are latched only when their metaframe passes the CRC check. Live status and sticky error flags can be read through a small register port, and a read clears the sticky flags.

Top module: `mfc_lane_checker`

## Requirements
- R1: `frame_lock` rises after the clock edge that takes the 4th consecutive sync word at a spacing of `cfg_mflen` valid words. A sync word is `in_ctl`=1 with `in_data`=64'h78F6_78F6_78F6_78F6. A missing sync while lock is being confirmed restarts the search, and the count starts again from one.
- R2: While locked, 4 consecutive missing or corrupt sync words at the expected slot clear `frame_lock` after the 4th. A good sync resets this count. Each missing sync while locked sets sticky error bit 0.
- R3: `rx_ready` is high only while both `blk_lock` and frame lock hold. When `blk_lock` goes low, `frame_lock` and `rx_ready` are low after the next edge, and lock must then be acquired again.
- R4: Skip words are never forwarded and raise no error flag. A skip word has `in_ctl`=1 and type `in_data[63:58]`=6'h07.
- R5: While locked, each valid word that is not a framing word appears on `out_ctl`/`out_data` with `out_valid`, one cycle after input. The framing types are sync 6'h1E, scrambler state 6'h0A, skip 6'h07 and diagnostic 6'h19. Other control types are forwarded. Nothing is forwarded while unlocked.
- R6: The check uses CRC-32 with polynomial 0x1EDC6F41, seed all ones, MSB first and the result inverted. It runs over the 64 data bits of every word in the metaframe, with diagnostic bits [31:0] taken as zero, and is compared with diagnostic bits [31:0]. A mismatch while locked pulses `crc_err` for one cycle after the diagnostic word and sets sticky bit 2.
- R7: On a diagnostic word with a good CRC, `lane_stat` takes bit 33 and `link_stat` takes bit 32. On a bad CRC both keep their previous values.
- R8: While locked, the word in slot 1 must be a scrambler state word whose bits [57:0] equal `dscr_state`. Any other word sets sticky bit 1.
- R9: A read of address 0 returns {link_stat, lane_stat, rx_ready, frame_lock, blk_lock} in bits 4..0. A read of address 1 returns the sticky bits {crc, scrambler, sync} in bits 2..0 and clears them, unless a new error arrives in the same cycle. `rd_data` is valid one cycle after `rd_en`.
- R10: Metaframe lengths from 5 to 8191 words are supported, including the minimum of 5 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_lock | input | 1 | Word-boundary lock from the aligner |
| cfg_mflen | input | 13 | Metaframe length in words (5..8191) |
| dscr_state | input | 58 | Descrambler state expected in the state word |
| in_valid | input | 1 | Input word valid |
| in_ctl | input | 1 | Input word is a control word |
| in_data | input | 64 | Input word data |
| out_valid | output | 1 | Payload word valid |
| out_ctl | output | 1 | Payload control flag |
| out_data | output | 64 | Payload data |
| rx_ready | output | 1 | Lane ready (word and frame lock) |
| frame_lock | output | 1 | Metaframe lock |
| crc_err | output | 1 | One-cycle CRC mismatch pulse |
| lane_stat | output | 1 | Latched far-end lane status |
| link_stat | output | 1 | Latched far-end link status |
| err_flags | output | 3 | Sticky errors {crc, scrambler, sync} |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register address |
| rd_data | output | 8 | Register read data |

## Verification
The assertions assume that `cfg_mflen` stays in range and changes only while the lane is unlocked. They also assume that `dscr_state` is steady over the metaframes that are checked. The stimulus meets these assumptions: it changes the length only after dropping `blk_lock`, and it holds one descrambler state for the whole run. The assertions further assume that skip and other control words never reuse the exact sync pattern. The generator builds each metaframe with the sync, state and diagnostic words in their fixed slots. Random data, skip and non-framing control words fill the slots between them, and idle gaps with `in_valid` low are mixed in.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int DW = 64;
  localparam logic [5:0]  TY_SYNC   = 6'h1E;
  localparam logic [5:0]  TY_STATE  = 6'h0A;
  localparam logic [5:0]  TY_SKIP   = 6'h07;
  localparam logic [5:0]  TY_DIAG   = 6'h19;
  localparam logic [63:0] SYNC_WORD = 64'h78F6_78F6_78F6_78F6;
  localparam logic [31:0] CRC_POLY  = 32'h1EDC6F41;
  localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {FS_HUNT, FS_CONFIRM, FS_LOCKED} fstate_t;

  typedef struct packed {
    logic sync;
    logic st;
    logic skip;
    logic diag;
    logic framing;
  } wkind_t;

  // One 64-bit word through the CRC, MSB first.
  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [DW-1:0] d);
    logic [31:0] c;
    logic fb;
    c = c_in;
    for (int i = DW-1; i >= 0; i--) begin
      fb = c[31] ^ d[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  function automatic wkind_t classify(input logic ctl, input logic [DW-1:0] d);
    wkind_t k;
    k.sync    = ctl && (d == SYNC_WORD);
    k.st      = ctl && (d[63:58] == TY_STATE);
    k.skip    = ctl && (d[63:58] == TY_SKIP);
    k.diag    = ctl && (d[63:58] == TY_DIAG);
    k.framing = ctl && ((d[63:58] == TY_SYNC) || (d[63:58] == TY_STATE) ||
                        (d[63:58] == TY_SKIP) || (d[63:58] == TY_DIAG));
    return k;
  endfunction
endpackage

// File: rtl/mfc_frame_lock.sv
module mfc_frame_lock
  import mfc_pkg::*;
#(
  parameter int LW     = 13,
  parameter int LOCK_N = 4,
  parameter int LOSS_N = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blk_lock,
  input  logic [LW-1:0] cfg_mflen,
  input  logic          in_valid,
  input  logic          is_sync,
  output logic          locked,
  output logic          lock_nxt,
  output logic          head,
  output logic          at_state,
  output logic          at_last,
  output logic          sync_err
);
  localparam int MAXN = (LOCK_N > LOSS_N) ? LOCK_N : LOSS_N;
  localparam int CW   = $clog2(MAXN) + 1;

  fstate_t       st_q, st_d;
  logic [LW-1:0] pos_q, pos_d, pos_inc;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          serr_d;
  logic          at_head;

  assign at_head  = (pos_q == '0);
  assign pos_inc  = (pos_q == cfg_mflen - 1'b1) ? '0 : pos_q + 1'b1;
  assign locked   = (st_q == FS_LOCKED);
  assign lock_nxt = (st_d == FS_LOCKED);
  assign head     = (st_q == FS_HUNT) ? 1'b1 : at_head;
  assign at_state = locked && (pos_q == LW'(1));
  assign at_last  = locked && (pos_q == cfg_mflen - 1'b1);

  always_comb begin
    st_d   = st_q;
    pos_d  = pos_q;
    cnt_d  = cnt_q;
    serr_d = 1'b0;
    if (!blk_lock) begin
      st_d  = FS_HUNT;
      cnt_d = '0;
    end else if (in_valid) begin
      case (st_q)
        FS_HUNT: begin
          if (is_sync) begin
            st_d  = FS_CONFIRM;
            pos_d = LW'(1);
            cnt_d = CW'(1);
          end
        end
        FS_CONFIRM: begin
          pos_d = pos_inc;
          if (at_head) begin
            if (is_sync) begin
              if (cnt_q == CW'(LOCK_N - 1)) begin
                st_d  = FS_LOCKED;
                cnt_d = '0;
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end else begin
              st_d  = FS_HUNT;
              cnt_d = '0;
            end
          end
        end
        FS_LOCKED: begin
          pos_d = pos_inc;
          if (at_head) begin
            if (is_sync) begin
              cnt_d = '0;
            end else begin
              serr_d = 1'b1;
              if (cnt_q == CW'(LOSS_N - 1)) begin
                st_d  = FS_HUNT;
                cnt_d = '0;
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end
          end
        end
        default: st_d = FS_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= FS_HUNT;
      pos_q    <= '0;
      cnt_q    <= '0;
      sync_err <= 1'b0;
    end else begin
      st_q     <= st_d;
      pos_q    <= pos_d;
      cnt_q    <= cnt_d;
      sync_err <= serr_d;
    end
  end

  // R1
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(in_valid && is_sync && blk_lock));
  // R2
  lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(!blk_lock || (in_valid && !is_sync)));
  // R3
  blk_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !blk_lock |=> !locked);
endmodule

// File: rtl/mfc_crc_check.sv
module mfc_crc_check
  import mfc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          is_diag,
  input  logic          head,
  input  logic          check_en,
  output logic          crc_err,
  output logic          lane_stat,
  output logic          link_stat
);
  logic [31:0] acc_q;
  logic [31:0] calc;
  logic        hit, bad;

  assign calc = ~crc_step(acc_q, {in_data[DW-1:32], 32'h0});
  assign hit  = in_valid && check_en && is_diag;
  assign bad  = (calc != in_data[31:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= CRC_SEED;
      crc_err   <= 1'b0;
      lane_stat <= 1'b0;
      link_stat <= 1'b0;
    end else begin
      crc_err <= hit && bad;
      if (in_valid)
        acc_q <= head ? crc_step(CRC_SEED, in_data) : crc_step(acc_q, in_data);
      if (hit && !bad) begin
        lane_stat <= in_data[33];
        link_stat <= in_data[32];
      end
    end
  end

  // R6
  crc_at_diag_chk: assert property (@(posedge clk) disable iff (rst)
    crc_err |-> $past(in_valid && is_diag && check_en));
  // R7
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    crc_err |-> ($stable(lane_stat) && $stable(link_stat)));
endmodule

// File: rtl/mfc_status_regs.sv
module mfc_status_regs #(
  parameter int AW = 2,
  parameter int RW = 8,
  parameter int NE = 3,
  parameter int LV = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NE-1:0] err_set,
  input  logic [LV-1:0] live,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [NE-1:0] sticky,
  output logic [RW-1:0] rd_data
);
  logic clr;
  assign clr = rd_en && (rd_addr == AW'(1));

  for (genvar i = 0; i < NE; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (rst) sticky[i] <= 1'b0;
      else     sticky[i] <= err_set[i] | (sticky[i] & ~clr);
    end

    // R9
    err_keep_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(sticky[i]) |-> $past(clr));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        AW'(0):  rd_data <= RW'(live);
        AW'(1):  rd_data <= RW'(sticky);
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mfc_lane_checker.sv
module mfc_lane_checker
  import mfc_pkg::*;
#(
  parameter int LW     = 13,
  parameter int LOCK_N = 4,
  parameter int LOSS_N = 4,
  parameter int AW     = 2,
  parameter int RW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blk_lock,
  input  logic [LW-1:0] cfg_mflen,
  input  logic [57:0]   dscr_state,
  input  logic          in_valid,
  input  logic          in_ctl,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic          out_ctl,
  output logic [DW-1:0] out_data,
  output logic          rx_ready,
  output logic          frame_lock,
  output logic          crc_err,
  output logic          lane_stat,
  output logic          link_stat,
  output logic [2:0]    err_flags,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [RW-1:0] rd_data
);
  localparam int NE = 3;
  localparam int LV = 5;

  wkind_t kind;
  logic   lock_nxt, head, at_state, at_last, sync_err;
  logic   scr_q, blk_q;

  assign kind = classify(in_ctl, in_data);

  mfc_frame_lock #(.LW(LW), .LOCK_N(LOCK_N), .LOSS_N(LOSS_N)) u_lock (
    .clk(clk), .rst(rst), .blk_lock(blk_lock), .cfg_mflen(cfg_mflen),
    .in_valid(in_valid), .is_sync(kind.sync),
    .locked(frame_lock), .lock_nxt(lock_nxt), .head(head),
    .at_state(at_state), .at_last(at_last), .sync_err(sync_err)
  );

  mfc_crc_check u_crc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .is_diag(kind.diag), .head(head), .check_en(at_last),
    .crc_err(crc_err), .lane_stat(lane_stat), .link_stat(link_stat)
  );

  mfc_status_regs #(.AW(AW), .RW(RW), .NE(NE), .LV(LV)) u_regs (
    .clk(clk), .rst(rst),
    .err_set({crc_err, scr_q, sync_err}),
    .live({link_stat, lane_stat, rx_ready, frame_lock, blk_q}),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .sticky(err_flags), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ctl   <= 1'b0;
      out_data  <= '0;
      rx_ready  <= 1'b0;
      scr_q     <= 1'b0;
      blk_q     <= 1'b0;
    end else begin
      out_valid <= in_valid && frame_lock && !kind.framing;
      if (in_valid && frame_lock && !kind.framing) begin
        out_ctl  <= in_ctl;
        out_data <= in_data;
      end
      rx_ready <= blk_lock && lock_nxt;
      scr_q    <= in_valid && at_state && (!kind.st || (in_data[57:0] != dscr_state));
      blk_q    <= blk_lock;
    end
  end

  // R3
  ready_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> (frame_lock && blk_q));
  // R4
  skip_dropped_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$past(kind.skip));
  // R5
  fwd_locked_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(frame_lock && in_valid));
  // R8
  scr_slot_chk: assert property (@(posedge clk) disable iff (rst)
    scr_q |-> $past(at_state && in_valid));
endmodule

// File: tb/sim_mfc_lane_checker.sv
`timescale 1ns/1ps
module sim_mfc_lane_checker;
  import mfc_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        blk_lock = 1'b0;
  logic [12:0] cfg_mflen = 13'd16;
  logic [57:0] dscr_state = '0;
  logic        in_valid = 1'b0, in_ctl = 1'b0;
  logic [63:0] in_data = '0;
  logic        out_valid, out_ctl, rx_ready, frame_lock, crc_err, lane_stat, link_stat;
  logic [63:0] out_data;
  logic [2:0]  err_flags;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data;

  int  n_chk = 0, n_bad = 0;
  logic exp_lane = 1'b0, exp_link = 1'b0;

  mfc_lane_checker u0 (
    .clk(clk), .rst(rst), .blk_lock(blk_lock), .cfg_mflen(cfg_mflen),
    .dscr_state(dscr_state), .in_valid(in_valid), .in_ctl(in_ctl), .in_data(in_data),
    .out_valid(out_valid), .out_ctl(out_ctl), .out_data(out_data),
    .rx_ready(rx_ready), .frame_lock(frame_lock), .crc_err(crc_err),
    .lane_stat(lane_stat), .link_stat(link_stat), .err_flags(err_flags),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c_in, input logic [63:0] d);
    logic [31:0] c = c_in;
    for (int b = 63; b >= 0; b--) begin
      if (c[31] ^ d[b]) c = {c[30:0], 1'b0} ^ 32'h1EDC6F41;
      else              c = {c[30:0], 1'b0};
    end
    return c;
  endfunction

  task automatic drive(input logic v, input logic c, input logic [63:0] d,
                       input logic eov, input logic ecrc);
    @(negedge clk);
    in_valid = v; in_ctl = c; in_data = d;
    @(posedge clk); #1;
    chk(out_valid == eov, "R5 out_valid", out_valid, eov);
    if (eov) chk({out_ctl, out_data} == {c, d}, "R5 payload", {out_ctl, out_data}, {c, d});
    chk(crc_err == ecrc, "R6 crc_err pulse", crc_err, ecrc);
    in_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    drive(1'b0, 1'b0, 64'h0, 1'b0, 1'b0);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #1; v = rd_data;
    rd_en = 1'b0;
  endtask

  // One metaframe of cfg_mflen words; lk = payload expected to be forwarded
  task automatic send_mf(input bit lk, input bit bad_sync, input bit bad_crc,
                         input bit bad_state, input bit lane, input bit link);
    logic [31:0] c;
    logic [63:0] w;
    int r;
    w = bad_sync ? (SYNC_WORD ^ 64'h0000_0000_0010_0000) : SYNC_WORD;
    c = ref_crc(32'hFFFF_FFFF, w);
    drive(1'b1, 1'b1, w, 1'b0, 1'b0);
    w = {TY_STATE, bad_state ? (dscr_state ^ 58'h5) : dscr_state};
    c = ref_crc(c, w);
    drive(1'b1, 1'b1, w, 1'b0, 1'b0);
    for (int p = 2; p < int'(cfg_mflen) - 1; p++) begin
      if ($urandom % 6 == 0) drive(1'b0, 1'b0, 64'h0, 1'b0, 1'b0);
      r = $urandom % 8;
      if (r == 0) begin
        w = {TY_SKIP, 26'($urandom), 32'($urandom)};  // R4 skip never forwarded
        c = ref_crc(c, w);
        drive(1'b1, 1'b1, w, 1'b0, 1'b0);
      end else if (r == 1) begin
        w = {6'h21, 26'($urandom), 32'($urandom)};
        c = ref_crc(c, w);
        drive(1'b1, 1'b1, w, lk, 1'b0);
      end else begin
        w = {32'($urandom), 32'($urandom)};
        c = ref_crc(c, w);
        drive(1'b1, 1'b0, w, lk, 1'b0);
      end
    end
    w = {TY_DIAG, 24'h0, lane, link, 32'h0};
    w[31:0] = ~ref_crc(c, w) ^ (bad_crc ? 32'h0000_0100 : 32'h0);
    drive(1'b1, 1'b1, w, 1'b0, lk && bad_crc);
    if (lk && !bad_crc) begin exp_lane = lane; exp_link = link; end
    chk(lane_stat == exp_lane, "R7 lane_stat", lane_stat, exp_lane);
    chk(link_stat == exp_link, "R7 link_stat", link_stat, exp_link);
  endtask

  task automatic acquire();
    for (int k = 0; k < 3; k++) begin
      send_mf(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk(frame_lock == 1'b0, "R1 not yet locked", frame_lock, 0);
    end
    send_mf(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(frame_lock == 1'b1, "R1 locked after 4 syncs", frame_lock, 1);
    chk(rx_ready == 1'b1, "R3 rx_ready when locked", rx_ready, 1);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    bit any_crc;
    void'($urandom(32'd20251));
    dscr_state = {26'($urandom), 32'($urandom)};
    blk_lock = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    chk(frame_lock == 1'b0, "R1 reset frame_lock", frame_lock, 0);
    chk(rx_ready == 1'b0, "R3 reset rx_ready", rx_ready, 0);
    chk(out_valid == 1'b0, "R5 reset out_valid", out_valid, 0);
    rd(2'd1, v); chk(v == 8'h00, "R9 reset sticky", v, 8'h00);
    rd(2'd0, v); chk(v == 8'h01, "R9 live after reset", v, 8'h01);

    // R1 confirmation broken by a missing sync restarts the count
    send_mf(0, 0, 0, 0, 0, 0);
    send_mf(0, 0, 0, 0, 0, 0);
    send_mf(0, 1, 0, 0, 0, 0);
    chk(frame_lock == 1'b0, "R1 miss during confirm", frame_lock, 0);
    acquire();
    rd(2'd1, v); chk(v == 8'h00, "R2 no error while unlocked", v, 8'h00);
    rd(2'd0, v); chk(v == 8'h0F, "R9 live locked", v, 8'h0F);

    // Random body: CRC errors and status updates, R4 skips cause no flags
    any_crc = 0;
    for (int m = 0; m < 40; m++) begin
      bit bc;
      bc = ($urandom % 4 == 0);
      any_crc |= bc;
      send_mf(1'b1, 1'b0, bc, 1'b0, 1'($urandom), 1'($urandom));
      chk(frame_lock == 1'b1, "R2 lock held", frame_lock, 1);
    end
    rd(2'd1, v);
    chk(v == {5'h0, any_crc, 2'b00}, "R6 sticky crc only (R4 no skip flag)", v, {5'h0, any_crc, 2'b00});
    rd(2'd1, v); chk(v == 8'h00, "R9 clear on read", v, 8'h00);

    // R8 scrambler state mismatch
    send_mf(1, 0, 0, 1, 0, 1);
    rd(2'd1, v); chk(v == 8'h02, "R8 scrambler sticky", v, 8'h02);

    // R2 three misses keep lock, good sync resets count, four misses drop it
    for (int k = 0; k < 3; k++) send_mf(1, 1, 0, 0, 1, 1);
    chk(frame_lock == 1'b1, "R2 lock after 3 misses", frame_lock, 1);
    rd(2'd1, v); chk(v == 8'h01, "R2 sync sticky", v, 8'h01);
    send_mf(1, 0, 0, 0, 0, 1);
    for (int k = 0; k < 3; k++) send_mf(1, 1, 0, 0, 1, 0);
    chk(frame_lock == 1'b1, "R2 count reset by good sync", frame_lock, 1);
    send_mf(0, 1, 0, 0, 0, 0);
    chk(frame_lock == 1'b0, "R2 lock lost after 4 misses", frame_lock, 0);
    chk(rx_ready == 1'b0, "R3 rx_ready drops with lock", rx_ready, 0);

    // R3 word-boundary loss drops lock at once
    acquire();
    @(negedge clk); blk_lock = 1'b0;
    @(posedge clk); #1;
    chk(frame_lock == 1'b0, "R3 frame_lock on blk loss", frame_lock, 0);
    chk(rx_ready == 1'b0, "R3 rx_ready on blk loss", rx_ready, 0);

    // R10 minimum metaframe length
    cfg_mflen = 13'd5;
    @(negedge clk); blk_lock = 1'b1;
    acquire();
    for (int m = 0; m < 12; m++) begin
      send_mf(1'b1, 1'b0, ($urandom % 3 == 0), 1'b0, 1'($urandom), 1'($urandom));
      chk(frame_lock == 1'b1, "R10 lock held at length 5", frame_lock, 1);
    end
    rd(2'd1, v);
    rd(2'd1, v); chk(v == 8'h00, "R9 second read empty", v, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule